// File: doc/BRIEF.md
# BCD Watchdog Timer with Expiry Steering

This block is a watchdog countdown for a system controller. Software loads the timeout as two-digit BCD bytes: one byte of hundredths of a second and one byte of whole seconds, which gives a longest timeout of 99.99 s. An external 100 Hz strobe, one clock wide, moves the count down by one hundredth. Every write to a count byte reloads the running counter from the full programmed value. This write is the "kick" that keeps the watchdog from firing.

When the enabled counter reaches zero, the block sets a sticky watchdog flag and reloads the counter. A steering bit picks what the expiry drives. When the bit is set, the block emits a reset pulse of fixed length. When it is clear, the block raises a level interrupt that stays high until software reads the flag register. A programmed value of zero disables expiry. Clearing the enable bit freezes the counter where it is.

The register port is a plain byte bus with single-cycle strobes. Write data is taken on the clock edge where the write strobe is high. Read data is combinational from the address. A read strobe has a side effect only on the flag register, where it clears the flag. The block carries no data stream, so none of its pins has a valid/ready handshake.

Top module: `bcd_watchdog`

## Requirements
- R1: After reset every register reads 0x00, and both the reset output and the interrupt output are low.
- R2: Offset 0x0C holds the hundredths byte and offset 0x0D holds the seconds byte; both read back exactly what was written. Offset 0x0F is the control byte: bit 1 is the enable and bit 0 is the steering bit, and bits 7..2 read 0.
- R3: When the watchdog is enabled with a programmed value of SS.hh (BCD), expiry happens on exactly the tick that completes the programmed number of hundredths after the load. No earlier tick causes an expiry. The hundredths digits borrow from the seconds digits and each digit wraps from 0 to 9, so 01.00 expires on the 100th tick and 99.99 expires on the 9999th tick.
- R4: Expiry sets bit 1 of the flag byte at offset 0x0E. A read of offset 0x0E returns the flag and clears it on the same clock edge.
- R5: When expiry occurs with the steering bit set, the reset output goes high in the cycle after the expiring tick and stays high for exactly 4 clock cycles. The interrupt output stays low.
- R6: When expiry occurs with the steering bit clear, the interrupt output goes high in the cycle after the expiring tick and stays high until a read of offset 0x0E. The reset output stays low.
- R7: A write to either count byte reloads the running counter from the full programmed value, so the countdown starts again from the beginning.
- R8: While the enable bit is clear, ticks are ignored and the counter holds its value. After the enable bit is set again, the countdown resumes from the held value.
- R9: A programmed value of 00.00 never expires, even while the watchdog is enabled and ticking.
- R10: On expiry the counter reloads the programmed value, so the next expiry comes after another full timeout.
- R11: When a count-byte write and a tick arrive in the same cycle, the reload wins and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One-cycle 100 Hz strobe; each strobe counts one hundredth |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe; used for the read-to-clear of the flag |
| addr_i | input | ADDR_W (5) | Register byte offset |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for `addr_i` (combinational) |
| wdt_rst_o | output | 1 | Reset pulse on steered expiry |
| wdt_irq_o | output | 1 | Interrupt level on non-steered expiry |

## Verification
The bench uses the default parameters: two count bytes, a 5-bit offset and a 4-cycle reset pulse. It drives the tick strobe back to back on every clock. With ticks that dense, even the 99.99 s maximum expires within ten thousand cycles, so the full borrow chain is exercised through every digit. The 4-cycle pulse can be measured edge to edge. A scoreboard records the exact cycle and the kind of each expected expiry. Any reset or interrupt edge that nobody predicted is therefore caught, and that covers early expiry, a lost kick and a counted tick under a disable.

// File: rtl/bcdwd_pkg.sv
package bcdwd_pkg;
  // register byte offsets (decoded by software)
  localparam int OFS_HUND = 12;
  localparam int OFS_SECS = 13;
  localparam int OFS_FLAG = 14;
  localparam int OFS_CTRL = 15;
  // bit positions
  localparam int CTRL_EN_BIT    = 1;
  localparam int CTRL_STEER_BIT = 0;
  localparam int FLAG_WD_BIT    = 1;

  // one BCD digit minus one, wrapping 0 to 9
  function automatic logic [3:0] digit_dec(input logic [3:0] d);
    return (d == 4'd0) ? 4'd9 : d - 4'd1;
  endfunction
endpackage

// File: rtl/bcdwd_counter.sv
module bcdwd_counter #(
  parameter int NUM_DIGITS = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    load_i,
  input  logic [4*NUM_DIGITS-1:0] load_val_i,
  input  logic                    step_i,
  output logic                    expire_o
);
  import bcdwd_pkg::*;
  localparam int W = 4 * NUM_DIGITS;

  logic [W-1:0]          cnt_q;
  logic [W-1:0]          dec_val;
  logic [NUM_DIGITS-1:0] borrow;
  logic                  is_zero, is_last;

  assign borrow[0] = 1'b1;
  for (genvar g = 0; g < NUM_DIGITS; g++) begin : g_digit
    assign dec_val[g*4 +: 4] = borrow[g] ? digit_dec(cnt_q[g*4 +: 4]) : cnt_q[g*4 +: 4];
    if (g < NUM_DIGITS - 1) begin : g_borrow
      assign borrow[g+1] = borrow[g] & (cnt_q[g*4 +: 4] == 4'd0);
    end
  end

  assign is_zero  = (cnt_q == '0);
  assign is_last  = (cnt_q == W'(1));
  assign expire_o = step_i & ~load_i & is_last;

  always_ff @(posedge clk) begin
    if (!rst_n)                   cnt_q <= '0;
    else if (load_i)              cnt_q <= load_val_i;
    else if (step_i && !is_zero)  cnt_q <= is_last ? load_val_i : dec_val;
  end

  assert_hold_when_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !load_i) |=> $stable(cnt_q));
  assert_zero_never_moves_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && is_zero) |=> is_zero);
  assert_reload_on_expiry_R10: assert property (@(posedge clk) disable iff (!rst_n)
    expire_o |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/bcdwd_regs.sv
module bcdwd_regs #(
  parameter int ADDR_W    = 5,
  parameter int NUM_BYTES = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [ADDR_W-1:0]      addr_i,
  input  logic [7:0]             wdata_i,
  input  logic                   expire_i,
  output logic [7:0]             rdata_o,
  output logic [8*NUM_BYTES-1:0] prog_val_o,
  output logic                   kick_o,
  output logic                   enable_o,
  output logic                   steer_o,
  output logic                   irq_o
);
  import bcdwd_pkg::*;

  logic [8*NUM_BYTES-1:0] prog_q;
  logic en_q, steer_q, flag_q, irq_q;
  logic hit_flag_rd, hit_ctrl_wr;

  assign hit_flag_rd = rd_en_i && (addr_i == ADDR_W'(OFS_FLAG));
  assign hit_ctrl_wr = wr_en_i && (addr_i == ADDR_W'(OFS_CTRL));

  // programmed value as it stands after this cycle's write
  for (genvar b = 0; b < NUM_BYTES; b++) begin : g_byte
    assign prog_val_o[b*8 +: 8] = (wr_en_i && addr_i == ADDR_W'(OFS_HUND + b))
                                  ? wdata_i : prog_q[b*8 +: 8];
  end

  always_comb begin
    kick_o = 1'b0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (wr_en_i && addr_i == ADDR_W'(OFS_HUND + b)) kick_o = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prog_q  <= '0;
      en_q    <= 1'b0;
      steer_q <= 1'b0;
      flag_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      prog_q <= prog_val_o;
      if (hit_ctrl_wr) begin
        en_q    <= wdata_i[CTRL_EN_BIT];
        steer_q <= wdata_i[CTRL_STEER_BIT];
      end
      if (expire_i)         flag_q <= 1'b1;
      else if (hit_flag_rd) flag_q <= 1'b0;
      if (expire_i && !steer_q) irq_q <= 1'b1;
      else if (hit_flag_rd)     irq_q <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int b = 0; b < NUM_BYTES; b++)
      if (addr_i == ADDR_W'(OFS_HUND + b)) rdata_o = prog_q[b*8 +: 8];
    if (addr_i == ADDR_W'(OFS_FLAG)) rdata_o[FLAG_WD_BIT] = flag_q;
    if (addr_i == ADDR_W'(OFS_CTRL)) begin
      rdata_o[CTRL_EN_BIT]    = en_q;
      rdata_o[CTRL_STEER_BIT] = steer_q;
    end
  end

  assign enable_o = en_q;
  assign steer_o  = steer_q;
  assign irq_o    = irq_q;

  assert_flag_sets_R4: assert property (@(posedge clk) disable iff (!rst_n)
    expire_i |=> flag_q);
endmodule

// File: rtl/bcdwd_pulse.sv
module bcdwd_pulse #(
  parameter int PULSE_CYC = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger_i,
  output logic pulse_o
);
  localparam int CNT_W = $clog2(PULSE_CYC + 1);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (trigger_i)       cnt_q <= CNT_W'(PULSE_CYC);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign pulse_o = (cnt_q != '0);

  assert_pulse_starts_R5: assert property (@(posedge clk) disable iff (!rst_n)
    trigger_i |=> pulse_o);
  assert_no_spurious_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!trigger_i && !pulse_o) |=> !pulse_o);
endmodule

// File: rtl/bcd_watchdog.sv
module bcd_watchdog #(
  parameter int ADDR_W    = 5,
  parameter int NUM_BYTES = 2,
  parameter int PULSE_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        wdata_i,
  output logic [7:0]        rdata_o,
  output logic              wdt_rst_o,
  output logic              wdt_irq_o
);
  localparam int NUM_DIGITS = 2 * NUM_BYTES;

  logic [8*NUM_BYTES-1:0] prog_val;
  logic kick, enable, steer, expire;

  bcdwd_regs #(.ADDR_W(ADDR_W), .NUM_BYTES(NUM_BYTES)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .rd_en_i(rd_en_i),
    .addr_i(addr_i), .wdata_i(wdata_i), .expire_i(expire),
    .rdata_o(rdata_o), .prog_val_o(prog_val), .kick_o(kick),
    .enable_o(enable), .steer_o(steer), .irq_o(wdt_irq_o)
  );

  bcdwd_counter #(.NUM_DIGITS(NUM_DIGITS)) u_count (
    .clk(clk), .rst_n(rst_n), .load_i(kick), .load_val_i(prog_val),
    .step_i(tick_i & enable), .expire_o(expire)
  );

  bcdwd_pulse #(.PULSE_CYC(PULSE_CYC)) u_pulse (
    .clk(clk), .rst_n(rst_n), .trigger_i(expire & steer), .pulse_o(wdt_rst_o)
  );

  assert_irq_only_unsteered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wdt_irq_o) |-> !$past(steer));
endmodule

// File: tb/bcd_watchdog_bench.sv
module bcd_watchdog_bench;
  localparam int K_RST = 1;
  localparam int K_IRQ = 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n = 1'b0, tick = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [4:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic wdt_rst, wdt_irq;

  bcd_watchdog u_bcd_watchdog (
    .clk(clk), .rst_n(rst_n), .tick_i(tick), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata),
    .wdt_rst_o(wdt_rst), .wdt_irq_o(wdt_irq)
  );

  int checks = 0, errors = 0, cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int    q_kind[$];
  int    q_cyc[$];
  string q_tag[$];

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, expv);
    end
  endtask

  // scoreboard monitor
  logic rst_prev = 1'b0, irq_prev = 1'b0;
  int   rst_w = 0;
  task automatic observe(input int kind);
    if (q_kind.size() == 0) begin
      check(1'b0, "R3", "unexpected expiry event kind", kind, 0);
    end else begin
      int k = q_kind.pop_front();
      int c = q_cyc.pop_front();
      string t = q_tag.pop_front();
      check(kind == k, t, "expiry output kind", kind, k);
      check(cyc == c, t, "expiry cycle", cyc, c);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (wdt_rst && !rst_prev) observe(K_RST);
      if (wdt_irq && !irq_prev) observe(K_IRQ);
      if (wdt_rst) rst_w++;
      else if (rst_prev) begin
        check(rst_w == 4, "R5", "reset pulse width", rst_w, 4);
        rst_w = 0;
      end
    end
    rst_prev = wdt_rst;
    irq_prev = wdt_irq;
  end

  // driver tasks
  task automatic wr(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(posedge clk); #1 wr_en = 1'b0;
  endtask

  task automatic wr_tick(input int a, input int d);
    @(negedge clk); wr_en = 1'b1; tick = 1'b1; addr = 5'(a); wdata = 8'(d);
    @(posedge clk); #1 wr_en = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int a, input int expv, input string tag);
    @(negedge clk); rd_en = 1'b1; addr = 5'(a);
    #1 check(rdata == 8'(expv), tag, $sformatf("read of 0x%0h", a), rdata, expv);
    @(posedge clk); #1 rd_en = 1'b0;
  endtask

  task automatic run_ticks(input int n, input int fire, input int kind, input string tag);
    for (int i = 1; i <= n; i++) begin
      @(negedge clk); tick = 1'b1;
      if (i == fire) begin
        q_kind.push_back(kind); q_cyc.push_back(cyc + 1); q_tag.push_back(tag);
      end
      @(posedge clk); #1 tick = 1'b0;
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog run did not complete actual=%0d expected=%0d", cyc, 0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check(wdt_rst == 1'b0 && wdt_irq == 1'b0, "R1", "outputs after reset", {wdt_rst, wdt_irq}, 0);
    rd(12, 0, "R1"); rd(13, 0, "R1"); rd(14, 0, "R1"); rd(15, 0, "R1");
    // R2: register map and readback
    wr(12, 8'h34); wr(13, 8'h12); wr(15, 8'hFF);
    rd(12, 8'h34, "R2"); rd(13, 8'h12, "R2"); rd(15, 8'h03, "R2");
    wr(15, 8'h00);
    // R3 + R5: 01.00 steered to reset, expiry on 100th tick
    wr(12, 8'h00); wr(13, 8'h01); wr(15, 8'h03);
    run_ticks(100, 100, K_RST, "R3");
    rd(14, 8'h02, "R4"); rd(14, 8'h00, "R4");
    // R10: reload after expiry gives another full timeout
    run_ticks(100, 100, K_RST, "R10");
    idle(6);
    check(wdt_irq == 1'b0, "R5", "irq stays low on steered expiry", wdt_irq, 0);
    rd(14, 8'h02, "R10");
    // R6: unsteered expiry raises irq until flag read
    wr(12, 8'h05); wr(13, 8'h00); wr(15, 8'h02);
    run_ticks(5, 5, K_IRQ, "R6");
    idle(3);
    check(wdt_irq == 1'b1, "R6", "irq held until flag read", wdt_irq, 1);
    rd(14, 8'h02, "R6");
    @(negedge clk);
    check(wdt_irq == 1'b0, "R6", "irq cleared by flag read", wdt_irq, 0);
    // R7: kick through hundredths byte, then through seconds byte
    wr(12, 8'h10);
    run_ticks(7, 0, K_IRQ, "R7");
    wr(12, 8'h10);
    run_ticks(10, 10, K_IRQ, "R7");
    rd(14, 8'h02, "R7");
    run_ticks(7, 0, K_IRQ, "R7");
    wr(13, 8'h00);
    run_ticks(10, 10, K_IRQ, "R7");
    rd(14, 8'h02, "R7");
    // R8: disable freezes the count, resume continues
    wr(12, 8'h05);
    run_ticks(3, 0, K_IRQ, "R8");
    wr(15, 8'h00);
    run_ticks(10, 0, K_IRQ, "R8");
    rd(14, 8'h00, "R8");
    wr(15, 8'h02);
    run_ticks(2, 2, K_IRQ, "R8");
    rd(14, 8'h02, "R8");
    // R9: zero never expires
    wr(12, 8'h00); wr(13, 8'h00);
    run_ticks(50, 0, K_IRQ, "R9");
    rd(14, 8'h00, "R9");
    check(wdt_irq == 1'b0, "R9", "no irq with zero timeout", wdt_irq, 0);
    // R11: write and tick in the same cycle, reload wins
    wr(12, 8'h03);
    run_ticks(2, 0, K_IRQ, "R11");
    wr_tick(12, 8'h03);
    run_ticks(3, 3, K_IRQ, "R11");
    rd(14, 8'h02, "R11");
    // R3: maximum timeout 99.99
    wr(12, 8'h99); wr(13, 8'h99); wr(15, 8'h03);
    run_ticks(9999, 9999, K_RST, "R3");
    idle(6);
    rd(14, 8'h02, "R3");
    idle(4);
    check(q_kind.size() == 0, "R3", "expected expiries still pending", q_kind.size(), 0);
    finish_run();
  end
endmodule